// File: doc/BRIEF.md
# Interrupt Routing and Masking Register Block

This block merges a set of hardware interrupt lines with software-raised requests. Each bit is gated by its own enable bit and then sent to one of two processor request outputs: a normal request or a fast request. Software reaches the block through a simple synchronous register port. The port carries a select, a write strobe, a byte address, write data, read data and a flag that marks the transaction as privileged. Reads return data in the same cycle. Writes take effect at the next rising clock edge.

Enables and software requests are each changed through two registers. One register only sets bits and the other only clears them, so no read-modify-write sequence is needed. A software request is added before the enable mask. It is therefore masked and routed exactly like a hardware line. A one-bit protection control, which only privileged transactions can change, can lock out all unprivileged traffic.

Register map (byte offsets, 32-bit words): 0x00 merged status, 0x04 normal-routed masked status, 0x08 fast-routed masked status, 0x0C route select (1 = fast, 0 = normal), 0x10 enable set (reads back the enables), 0x14 enable clear, 0x18 software set (reads back the software requests), 0x1C software clear, 0x20 protection (bit 0).

Top module: `irq_route_regs`

## Requirements
- R1: After reset the enables, software requests, route selects and protection bit are all 0, and both request outputs are low.
- R2: A permitted read of offset 0x00 returns the hardware lines OR the software request bits, with no masking applied.
- R3: A permitted write to offset 0x10 sets each enable bit whose write-data bit is 1 and leaves the other enable bits unchanged. A read of 0x10 returns the enables.
- R4: A permitted write to offset 0x14 clears each enable bit whose write-data bit is 1. The other enable bits are unchanged.
- R5: A permitted write to 0x18 sets software request bits where the data is 1, and a write to 0x1C clears them where the data is 1. A software request is masked and routed like a hardware line.
- R6: The value at 0x04 is merged AND enable AND NOT route. The value at 0x08 is merged AND enable AND route. Offset 0x0C is read/write and holds the route bits.
- R7: The normal request output is the OR of all bits of the 0x04 value. The fast request output is the OR of all bits of the 0x08 value.
- R8: While the protection bit is 1, an unprivileged access reads back 0 and its write changes nothing. A privileged access is served normally.
- R9: The protection bit (offset 0x20, bit 0) changes only on a privileged write. A privileged read returns it, and an unprivileged read of it returns 0.
- R10: Writes to 0x00, 0x04 and 0x08 change nothing. Reads of 0x14, 0x1C, unmapped offsets, misaligned addresses and write cycles return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Hardware interrupt lines, active high |
| bus_sel_i | input | 1 | Register access valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_priv_i | input | 1 | Transaction is privileged |
| bus_rdata_o | output | DATA_W | Read data, valid in the access cycle |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Directed sequences come first. A fixed hardware pattern with every enable off separates merging from masking. Set writes that carry zeros show whether the set register preserves the bits it does not address. A split route pattern shows whether each line goes to the correct output. A software request on an otherwise idle line shows that it enters ahead of the mask. Locked-out unprivileged reads and writes, including attempts on the protection bit, show gating by privilege rather than by address. A long stretch of pseudo-random traffic follows, with random privilege, addresses and source lines, and every clock is compared against a behavioural model.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
   // word index of each register; the byte offset is index * 4
   typedef enum logic [3:0] {
      RG_RAW    = 4'd0,
      RG_IRQST  = 4'd1,
      RG_FIQST  = 4'd2,
      RG_ROUTE  = 4'd3,
      RG_EN_SET = 4'd4,
      RG_EN_CLR = 4'd5,
      RG_SW_SET = 4'd6,
      RG_SW_CLR = 4'd7,
      RG_PROT   = 4'd8
   } reg_idx_e;

   localparam int REG_COUNT = 9;

   localparam int OFS_RAW    = 32'h00;
   localparam int OFS_IRQST  = 32'h04;
   localparam int OFS_FIQST  = 32'h08;
   localparam int OFS_ROUTE  = 32'h0C;
   localparam int OFS_EN_SET = 32'h10;
   localparam int OFS_EN_CLR = 32'h14;
   localparam int OFS_SW_SET = 32'h18;
   localparam int OFS_SW_CLR = 32'h1C;
   localparam int OFS_PROT   = 32'h20;

   typedef struct packed {
      logic route;
      logic en_set;
      logic en_clr;
      logic sw_set;
      logic sw_clr;
      logic prot;
   } wr_strb_t;
endpackage

// File: rtl/irq_bus_guard.sv
`timescale 1ns/1ps
module irq_bus_guard
   import irq_route_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              priv_i,
   input  logic              prot_q_i,
   output logic              rd_ok_o,
   output reg_idx_e          idx_o,
   output wr_strb_t          strb_o
);
   logic [ADDR_W-1:0] word;
   logic              hit;
   logic              allowed;
   logic              wr_go;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("irq_bus_guard: ADDR_W must be at least 6");
   end

   always_comb begin
      word    = addr_i >> 2;
      hit     = (addr_i[1:0] == 2'b00) && (word < ADDR_W'(REG_COUNT));
      allowed = !prot_q_i || priv_i;
      idx_o   = hit ? reg_idx_e'(word[3:0]) : RG_RAW;
      rd_ok_o = sel_i && !wr_i && allowed && hit;
      wr_go   = sel_i && wr_i && allowed && hit;
      strb_o.route  = wr_go && (idx_o == RG_ROUTE);
      strb_o.en_set = wr_go && (idx_o == RG_EN_SET);
      strb_o.en_clr = wr_go && (idx_o == RG_EN_CLR);
      strb_o.sw_set = wr_go && (idx_o == RG_SW_SET);
      strb_o.sw_clr = wr_go && (idx_o == RG_SW_CLR);
      strb_o.prot   = wr_go && (idx_o == RG_PROT) && priv_i;
   end
endmodule

// File: rtl/irq_bit_bank.sv
`timescale 1ns/1ps
module irq_bit_bank #(
   parameter int N         = 32,
   parameter bit LOAD_MODE = 1'b0   // 0: set/clear-by-ones, 1: plain load
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         set_i,
   input  logic         clr_i,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o
);
   if (N < 1) begin : g_bad_n
      $error("irq_bit_bank: N must be positive");
   end

   for (genvar b = 0; b < N; b++) begin : g_bit
      if (LOAD_MODE) begin : g_load
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)    q_o[b] <= 1'b0;
            else if (clr_i) q_o[b] <= 1'b0;
            else if (set_i) q_o[b] <= d_i[b];
         end
      end else begin : g_setclr
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                q_o[b] <= 1'b0;
            else if (clr_i && d_i[b])   q_o[b] <= 1'b0;
            else if (set_i && d_i[b])   q_o[b] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_mask_route.sv
`timescale 1ns/1ps
module irq_mask_route #(
   parameter int N = 32
) (
   input  logic [N-1:0] src_i,
   input  logic [N-1:0] soft_i,
   input  logic [N-1:0] en_i,
   input  logic [N-1:0] route_i,
   output logic [N-1:0] raw_o,
   output logic [N-1:0] irq_st_o,
   output logic [N-1:0] fiq_st_o,
   output logic         irq_o,
   output logic         fiq_o
);
   logic [N-1:0] live;

   always_comb begin
      raw_o    = src_i | soft_i;
      live     = raw_o & en_i;
      irq_st_o = live & ~route_i;
      fiq_st_o = live & route_i;
      irq_o    = |irq_st_o;
      fiq_o    = |fiq_st_o;
   end
endmodule

// File: rtl/irq_route_regs.sv
`timescale 1ns/1ps
module irq_route_regs
   import irq_route_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_sel_i,
   input  logic               bus_wr_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   input  logic               bus_priv_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   output logic               irq_o,
   output logic               fiq_o
);
   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("irq_route_regs: NUM_SRC must be within 1..DATA_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("irq_route_regs: DATA_W must be positive");
   end

   logic [NUM_SRC-1:0] wd;
   logic [NUM_SRC-1:0] en_q, soft_q, route_q;
   logic [NUM_SRC-1:0] raw, irq_st, fiq_st;
   logic               prot_q;
   logic               rd_ok;
   reg_idx_e           idx;
   wr_strb_t           strb;

   assign wd = bus_wdata_i[NUM_SRC-1:0];

   irq_bus_guard #(.ADDR_W(ADDR_W)) u_guard (
      .sel_i    (bus_sel_i),
      .wr_i     (bus_wr_i),
      .addr_i   (bus_addr_i),
      .priv_i   (bus_priv_i),
      .prot_q_i (prot_q),
      .rd_ok_o  (rd_ok),
      .idx_o    (idx),
      .strb_o   (strb)
   );

   irq_bit_bank #(.N(NUM_SRC), .LOAD_MODE(1'b0)) u_en (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .set_i (strb.en_set), .clr_i (strb.en_clr),
      .d_i   (wd), .q_o (en_q)
   );

   irq_bit_bank #(.N(NUM_SRC), .LOAD_MODE(1'b0)) u_soft (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .set_i (strb.sw_set), .clr_i (strb.sw_clr),
      .d_i   (wd), .q_o (soft_q)
   );

   irq_bit_bank #(.N(NUM_SRC), .LOAD_MODE(1'b1)) u_route (
      .clk_i (clk_i), .rst_ni (rst_ni),
      .set_i (strb.route), .clr_i (1'b0),
      .d_i   (wd), .q_o (route_q)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        prot_q <= 1'b0;
      else if (strb.prot) prot_q <= bus_wdata_i[0];
   end

   irq_mask_route #(.N(NUM_SRC)) u_route_logic (
      .src_i    (src_i),
      .soft_i   (soft_q),
      .en_i     (en_q),
      .route_i  (route_q),
      .raw_o    (raw),
      .irq_st_o (irq_st),
      .fiq_st_o (fiq_st),
      .irq_o    (irq_o),
      .fiq_o    (fiq_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      if (rd_ok) begin
         unique case (idx)
            RG_RAW:    bus_rdata_o = DATA_W'(raw);
            RG_IRQST:  bus_rdata_o = DATA_W'(irq_st);
            RG_FIQST:  bus_rdata_o = DATA_W'(fiq_st);
            RG_ROUTE:  bus_rdata_o = DATA_W'(route_q);
            RG_EN_SET: bus_rdata_o = DATA_W'(en_q);
            RG_SW_SET: bus_rdata_o = DATA_W'(soft_q);
            RG_PROT:   bus_rdata_o = DATA_W'(prot_q && bus_priv_i);
            default:   bus_rdata_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/irq_route_chk.sv
`timescale 1ns/1ps
module irq_route_chk
   import irq_route_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [NUM_SRC-1:0] src_i,
   input logic               bus_sel_i,
   input logic               bus_wr_i,
   input logic [ADDR_W-1:0]  bus_addr_i,
   input logic [DATA_W-1:0]  bus_wdata_i,
   input logic               bus_priv_i,
   input logic [DATA_W-1:0]  bus_rdata_o,
   input logic               irq_o,
   input logic               fiq_o,
   input logic [NUM_SRC-1:0] en_q,
   input logic [NUM_SRC-1:0] soft_q,
   input logic [NUM_SRC-1:0] route_q,
   input logic               prot_q
);
   logic okay, wr_ok, rd_ok, user_blk;

   always_comb begin
      okay     = bus_sel_i && (!prot_q || bus_priv_i);
      wr_ok    = okay && bus_wr_i;
      rd_ok    = okay && !bus_wr_i;
      user_blk = bus_sel_i && prot_q && !bus_priv_i;
   end

   AST_RAW_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_ok && bus_addr_i == ADDR_W'(OFS_RAW)) |-> bus_rdata_o == DATA_W'(src_i | soft_q)); // R2
   AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && bus_addr_i == ADDR_W'(OFS_EN_SET)) |=>
      en_q == ($past(en_q) | $past(bus_wdata_i[NUM_SRC-1:0]))); // R3
   AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && bus_addr_i == ADDR_W'(OFS_EN_CLR)) |=>
      en_q == ($past(en_q) & ~$past(bus_wdata_i[NUM_SRC-1:0]))); // R4
   AST_SW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && bus_addr_i == ADDR_W'(OFS_SW_SET)) |=>
      soft_q == ($past(soft_q) | $past(bus_wdata_i[NUM_SRC-1:0]))); // R5
   AST_NO_EN_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q == '0) |-> (!irq_o && !fiq_o)); // R6
   AST_USER_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (user_blk && !bus_wr_i) |-> bus_rdata_o == '0); // R8
   AST_USER_WR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (user_blk && bus_wr_i) |=> ($stable(en_q) && $stable(soft_q) && $stable(route_q) && $stable(prot_q))); // R8
   AST_PROT_PRIV_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_sel_i && bus_wr_i && bus_priv_i) |=> $stable(prot_q)); // R9
   AST_STATUS_WR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(OFS_RAW) || bus_addr_i == ADDR_W'(OFS_IRQST)
       || bus_addr_i == ADDR_W'(OFS_FIQST))) |=>
      ($stable(en_q) && $stable(soft_q) && $stable(route_q) && $stable(prot_q))); // R10
endmodule

bind irq_route_regs irq_route_chk #(
   .NUM_SRC (NUM_SRC),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W)
) i_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .src_i       (src_i),
   .bus_sel_i   (bus_sel_i),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_priv_i  (bus_priv_i),
   .bus_rdata_o (bus_rdata_o),
   .irq_o       (irq_o),
   .fiq_o       (fiq_o),
   .en_q        (en_q),
   .soft_q      (soft_q),
   .route_q     (route_q),
   .prot_q      (prot_q)
);

// File: tb/test_irq_route_regs.sv
`timescale 1ns/1ps
module test_irq_route_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic        sel = 1'b0, wr = 1'b0, priv = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, fiq;

   int    n_run = 0, n_fail = 0;
   string cur_tag = "R1";
   bit    done = 1'b0;

   logic [31:0] m_en = '0, m_soft = '0, m_route = '0;
   logic        m_prot = 1'b0;

   always #2.5 clk = ~clk;

   irq_route_regs i_irq_route_regs (
      .clk_i (clk), .rst_ni (rst_n), .src_i (src),
      .bus_sel_i (sel), .bus_wr_i (wr), .bus_addr_i (addr),
      .bus_wdata_i (wdata), .bus_priv_i (priv), .bus_rdata_o (rdata),
      .irq_o (irq), .fiq_o (fiq)
   );

   function automatic logic [31:0] exp_rd();
      logic [31:0] raw;
      raw = src | m_soft;
      if (!sel || wr || (m_prot && !priv)) return '0;
      case (addr)
         8'h00: return raw;
         8'h04: return raw & m_en & ~m_route;
         8'h08: return raw & m_en & m_route;
         8'h0C: return m_route;
         8'h10: return m_en;
         8'h18: return m_soft;
         8'h20: return {31'd0, m_prot && priv};
         default: return '0;
      endcase
   endfunction

   // behavioural reference: state follows each accepted write
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = '0; m_soft = '0; m_route = '0; m_prot = 1'b0;
      end else if (sel && wr && (!m_prot || priv)) begin
         case (addr)
            8'h0C: m_route = wdata;
            8'h10: m_en    = m_en | wdata;
            8'h14: m_en    = m_en & ~wdata;
            8'h18: m_soft  = m_soft | wdata;
            8'h1C: m_soft  = m_soft & ~wdata;
            8'h20: if (priv) m_prot = wdata[0];
            default: ;
         endcase
      end
   end

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // compare against the model once per clock, away from the edge
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         logic [31:0] raw;
         raw = src | m_soft;
         chk(cur_tag, "rdata", rdata, exp_rd());
         chk("R7", "irq", {31'd0, irq}, {31'd0, |(raw & m_en & ~m_route)});
         chk("R7", "fiq", {31'd0, fiq}, {31'd0, |(raw & m_en & m_route)});
      end
   end

   task automatic acc(input bit w, input logic [7:0] a, input logic [31:0] d, input bit p, input string tag);
      @(negedge clk);
      sel = 1'b1; wr = w; addr = a; wdata = d; priv = p; cur_tag = tag;
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; cur_tag = tag;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk("R1", "irq after reset", {31'd0, irq}, 32'd0);
      chk("R1", "fiq after reset", {31'd0, fiq}, 32'd0);
      acc(0, 8'h10, 0, 1, "R1");
      acc(0, 8'h0C, 0, 1, "R1");
      acc(0, 8'h18, 0, 1, "R1");
      acc(0, 8'h20, 0, 1, "R1");
      // merged view without masking
      src = 32'hA5A5_0000;
      acc(0, 8'h00, 0, 0, "R2");
      acc(0, 8'h04, 0, 0, "R6");
      // enable set with zeros must keep bits
      acc(1, 8'h10, 32'hA500_00FF, 0, "R3");
      acc(1, 8'h10, 32'h0000_0000, 0, "R3");
      acc(0, 8'h10, 0, 0, "R3");
      acc(1, 8'h14, 32'h0000_0005, 0, "R4");
      acc(0, 8'h10, 0, 0, "R4");
      acc(0, 8'h14, 0, 0, "R10");
      // split routing
      acc(1, 8'h0C, 32'h2500_0000, 0, "R6");
      acc(0, 8'h0C, 0, 0, "R6");
      acc(0, 8'h04, 0, 0, "R6");
      acc(0, 8'h08, 0, 0, "R6");
      // software request on an idle line
      src = '0;
      acc(1, 8'h18, 32'h0000_0010, 0, "R5");
      acc(0, 8'h00, 0, 0, "R5");
      acc(0, 8'h08, 0, 0, "R5");
      acc(1, 8'h0C, 32'h0000_0010, 0, "R5");
      acc(0, 8'h08, 0, 0, "R5");
      acc(1, 8'h1C, 32'h0000_0010, 0, "R5");
      acc(0, 8'h18, 0, 0, "R5");
      acc(0, 8'h1C, 0, 0, "R10");
      // status registers are read-only
      acc(1, 8'h00, 32'hFFFF_FFFF, 0, "R10");
      acc(1, 8'h04, 32'hFFFF_FFFF, 0, "R10");
      acc(1, 8'h08, 32'hFFFF_FFFF, 0, "R10");
      acc(0, 8'h10, 0, 0, "R10");
      acc(0, 8'h3C, 0, 0, "R10");
      acc(0, 8'h12, 0, 0, "R10");
      // protection
      acc(1, 8'h20, 1, 0, "R9");
      acc(0, 8'h20, 0, 1, "R9");
      acc(1, 8'h20, 1, 1, "R9");
      acc(0, 8'h20, 0, 1, "R9");
      acc(0, 8'h20, 0, 0, "R9");
      acc(0, 8'h10, 0, 0, "R8");
      acc(1, 8'h10, 32'hFFFF_FFFF, 0, "R8");
      acc(1, 8'h20, 0, 0, "R8");
      acc(0, 8'h10, 0, 1, "R8");
      acc(0, 8'h20, 0, 1, "R8");
      acc(1, 8'h20, 0, 1, "R9");
      acc(0, 8'h20, 0, 1, "R9");
      // pseudo-random traffic
      for (int i = 0; i < 600; i++) begin
         logic [31:0] r;
         r = $urandom;
         src = $urandom & $urandom;
         acc(r[0], {2'b00, 4'(r[7:4] % 4'd10), 2'b00} | ((r[11:8] == 4'hF) ? 8'h41 : 8'h00),
             $urandom, (r[15:12] != 4'd0), "R6");
      end
      idle("R7");
      idle("R7");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule